// File: doc/BRIEF.md
# I2S and TDM Audio Serializer

This block is the transmit half of a clock-master audio port. From the system clock it derives a bit clock through an integer divider. It generates a word-select line, which in TDM mode serves as a frame-sync pulse. It shifts PCM samples out on a single serial data line, most significant bit first. Four framing formats share one datapath: standard I2S, left-justified, right-justified, and TDM with 4, 8, 16 or 32 slots. Slot width and sample word length are set at run time.

Samples are supplied one slot at a time. The block shows the index of the slot it wants next on `s_slot` and raises `s_ready` while its one-entry holding register is empty. A sample is taken on any system clock where `s_valid` and `s_ready` are both high. If no sample has arrived when a slot begins, the slot is sent as all zeros and `underrun` pulses.

Configuration inputs are sampled only at a frame boundary, so a change never splits a frame. The bit clock rate is the system clock rate divided by 2×(`cfg_div`+1). The frame length is slot width × slot count.

Top module: `audio_ser_top`

## Requirements
- R1: While reset is held, `bclk`, `ws`, `sd` and `underrun` are 0, `s_ready` is 1 and `s_slot` is 0.
- R2: Each level of `bclk` lasts `cfg_div`+1 system clocks, so a full bit period is 2×(`cfg_div`+1) clocks.
- R3: `sd` and `ws` change only in the clock where `bclk` falls, so that a receiver can sample them on the rising edge.
- R4: With `cfg_fmt`=0 (I2S) there are two slots. `ws` is 1 on frame bit positions W-1 through 2W-2 and 0 elsewhere, so it changes one bit before each MSB. The left sample begins at position 0, MSB first, and bits after the word length are 0.
- R5: With `cfg_fmt`=1 (left-justified) there are two slots. `ws` is 1 throughout slot 0 and 0 throughout slot 1. Each slot starts with its sample's MSB, and bits after the word length are 0.
- R6: With `cfg_fmt`=2 (right-justified) `ws` is the same as in R5, but the LSB falls on the last bit of each slot and the leading W-L bits are 0.
- R7: With `cfg_fmt`=3 (TDM) the slot count is 4 shifted left by `cfg_tdm_sel`. `ws` is a one-bit pulse on the last bit of the frame. Slot 0 begins, MSB first and left-aligned, on the next bit, and the slots follow back to back.
- R8: `s_ready` stays 1 until a sample is taken. `s_slot` names the slot that the next sample is sent in, and slot indices advance 0, 1, … N-1 and then wrap.
- R9: A slot that begins with no sample held is sent as all zeros, and `underrun` is high for exactly one clock at that point.
- R10: Format, slot count, slot width, word length and divider change only at the first bit of a frame. A frame that is in progress completes with the settings it started with.
- R11: Sample bits at and above the word length L do not affect `sd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fmt | input | 2 | Format: 0 I2S, 1 left-justified, 2 right-justified, 3 TDM |
| cfg_tdm_sel | input | 2 | TDM slot count select: 4 << value |
| cfg_slot_w | input | 6 | Slot width W in bits (2 to 32) |
| cfg_word_len | input | 6 | Sample word length L (1 to W) |
| cfg_div | input | 8 | Bit clock half-period minus one, in system clocks |
| s_valid | input | 1 | Sample offered |
| s_data | input | 32 | Sample, right-aligned in the word |
| s_ready | output | 1 | Holding register empty; sample accepted when s_valid is also high |
| s_slot | output | 5 | Slot index the next accepted sample goes to |
| bclk | output | 1 | Bit clock |
| ws | output | 1 | Word select, or frame sync in TDM |
| sd | output | 1 | Serial data |
| underrun | output | 1 | One-clock pulse when a slot starts with no sample |

## Verification
Some properties are checked on every cycle. Serial data and word select move only on a falling bit clock edge. An underrun slot loads an all-zero shifter. The slot index offered upstream always matches the slot being loaded. Latched settings change only at frame starts, and the divider count never passes its limit. Other behaviour can only be shown by the bench's scenarios: the exact alignment of word select and data in each format, MSB-first order, right-justified zero padding, masking of bits above the word length, TDM pulse placement across 8 and 32 slots, and the deferral of a mid-frame configuration change. The bench shows these by decoding the line as a receiver would and comparing against a model built from the requirements.

// File: rtl/audio_ser_pkg.sv
package audio_ser_pkg;

    localparam int unsigned SMP_W  = 32;
    localparam int unsigned BIT_W  = $clog2(SMP_W);
    localparam int unsigned LEN_W  = BIT_W + 1;
    localparam int unsigned SLOT_W = 5;
    localparam int unsigned DIV_W  = 8;

    typedef enum logic [1:0] {
        FMT_I2S = 2'd0,
        FMT_LJ  = 2'd1,
        FMT_RJ  = 2'd2,
        FMT_TDM = 2'd3
    } fmt_e;

    typedef struct packed {
        fmt_e              fmt;
        logic [1:0]        tdm_sel;
        logic [LEN_W-1:0]  slot_w;
        logic [LEN_W-1:0]  word_len;
        logic [DIV_W-1:0]  half_div;
    } cfg_t;

    function automatic logic [LEN_W-1:0] slots_of(cfg_t c);
        if (c.fmt == FMT_TDM)
            return LEN_W'(4) << c.tdm_sel;
        return LEN_W'(2);
    endfunction

    function automatic logic ws_level(cfg_t c, logic [SLOT_W-1:0] slot,
                                      logic [BIT_W-1:0] bitn);
        logic last_bit;
        last_bit = (LEN_W'(bitn) == c.slot_w - 1'b1);
        case (c.fmt)
            FMT_I2S: return (slot == 0 && last_bit) || (slot == 1 && !last_bit);
            FMT_TDM: return last_bit && (LEN_W'(slot) == slots_of(c) - 1'b1);
            default: return slot == 0;
        endcase
    endfunction

    function automatic logic [SMP_W-1:0] align_sample(cfg_t c, logic [SMP_W-1:0] d);
        logic [SMP_W-1:0] m;
        logic [LEN_W-1:0] amt;
        m = d & ~({SMP_W{1'b1}} << c.word_len);
        if (c.fmt == FMT_RJ)
            amt = LEN_W'(SMP_W) - c.slot_w;
        else
            amt = LEN_W'(SMP_W) - c.word_len;
        return m << amt;
    endfunction

endpackage

// File: rtl/audio_ser_bclk.sv
module audio_ser_bclk
    import audio_ser_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] half_div,
    output logic             bclk,
    output logic             fall_evt
);

    logic [DIV_W-1:0] cnt_q;
    logic             hit;

    assign hit      = (cnt_q == half_div);
    assign fall_evt = hit && bclk;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            bclk  <= 1'b0;
        end else if (hit) begin
            cnt_q <= '0;
            bclk  <= ~bclk;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= half_div); // R2

endmodule

// File: rtl/audio_ser_frame.sv
module audio_ser_frame
    import audio_ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  cfg_t              cfg_in,
    output cfg_t              cfg_act,
    output cfg_t              nxt_cfg,
    output logic [SLOT_W-1:0] nxt_slot,
    output logic [BIT_W-1:0]  nxt_bit,
    output logic              slot_start,
    output logic              frame_start
);

    logic [SLOT_W-1:0] slot_q;
    logic [BIT_W-1:0]  bit_q;
    logic              started_q;
    logic              last_bit, last_slot, wrap;

    assign last_bit  = (LEN_W'(bit_q) == cfg_act.slot_w - 1'b1);
    assign last_slot = (LEN_W'(slot_q) == slots_of(cfg_act) - 1'b1);
    assign wrap      = !started_q || (last_bit && last_slot);

    always_comb begin
        nxt_cfg  = cfg_act;
        nxt_slot = slot_q;
        nxt_bit  = bit_q + 1'b1;
        if (wrap) begin
            nxt_cfg  = cfg_in;
            nxt_slot = '0;
            nxt_bit  = '0;
        end else if (last_bit) begin
            nxt_slot = slot_q + 1'b1;
            nxt_bit  = '0;
        end
    end

    assign slot_start  = adv && (nxt_bit == '0);
    assign frame_start = adv && wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_act   <= cfg_in;
            slot_q    <= '0;
            bit_q     <= '0;
            started_q <= 1'b0;
        end else if (adv) begin
            cfg_act   <= nxt_cfg;
            slot_q    <= nxt_slot;
            bit_q     <= nxt_bit;
            started_q <= 1'b1;
        end
    end

    AST_CFG_AT_FRAME: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_act) |-> $past(frame_start)); // R10

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
        LEN_W'(slot_q) < slots_of(cfg_act)); // R7

endmodule

// File: rtl/audio_ser_feed.sv
module audio_ser_feed
    import audio_ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              s_valid,
    input  logic [SMP_W-1:0]  s_data,
    output logic              s_ready,
    output logic [SLOT_W-1:0] s_slot,
    input  logic              load,
    input  logic [SLOT_W-1:0] load_slot,
    input  logic [LEN_W-1:0]  nslots,
    output logic              have,
    output logic [SMP_W-1:0]  use_data
);

    logic [SMP_W-1:0]  buf_q;
    logic              full_q;
    logic [SLOT_W-1:0] req_q;
    logic [LEN_W-1:0]  inc;

    assign s_ready  = !full_q;
    assign s_slot   = req_q;
    assign have     = full_q || s_valid;
    assign use_data = full_q ? buf_q : s_data;
    assign inc      = LEN_W'(load_slot) + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q  <= '0;
            full_q <= 1'b0;
            req_q  <= '0;
        end else if (load) begin
            full_q <= 1'b0;
            req_q  <= (inc == nslots) ? '0 : inc[SLOT_W-1:0];
        end else if (s_valid && !full_q) begin
            buf_q  <= s_data;
            full_q <= 1'b1;
        end
    end

    AST_SLOT_MATCH: assert property (@(posedge clk) disable iff (rst)
        load |-> (s_slot == load_slot)); // R8

    AST_READY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (s_ready && !s_valid) |=> s_ready); // R8

endmodule

// File: rtl/audio_ser_top.sv
module audio_ser_top
    import audio_ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_fmt,
    input  logic [1:0]        cfg_tdm_sel,
    input  logic [LEN_W-1:0]  cfg_slot_w,
    input  logic [LEN_W-1:0]  cfg_word_len,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              s_valid,
    input  logic [SMP_W-1:0]  s_data,
    output logic              s_ready,
    output logic [SLOT_W-1:0] s_slot,
    output logic              bclk,
    output logic              ws,
    output logic              sd,
    output logic              underrun
);

    cfg_t              cfg_in, cfg_act, nxt_cfg;
    logic [SLOT_W-1:0] nxt_slot;
    logic [BIT_W-1:0]  nxt_bit;
    logic              adv, slot_start, frame_start, have;
    logic [SMP_W-1:0]  use_data;
    logic [SMP_W-1:0]  sh_q;
    logic              ws_q, ur_q;

    assign cfg_in = '{fmt: fmt_e'(cfg_fmt), tdm_sel: cfg_tdm_sel,
                      slot_w: cfg_slot_w, word_len: cfg_word_len,
                      half_div: cfg_div};

    audio_ser_bclk u_bclk (
        .clk      (clk),
        .rst      (rst),
        .half_div (cfg_act.half_div),
        .bclk     (bclk),
        .fall_evt (adv)
    );

    audio_ser_frame u_frame (
        .clk         (clk),
        .rst         (rst),
        .adv         (adv),
        .cfg_in      (cfg_in),
        .cfg_act     (cfg_act),
        .nxt_cfg     (nxt_cfg),
        .nxt_slot    (nxt_slot),
        .nxt_bit     (nxt_bit),
        .slot_start  (slot_start),
        .frame_start (frame_start)
    );

    audio_ser_feed u_feed (
        .clk       (clk),
        .rst       (rst),
        .s_valid   (s_valid),
        .s_data    (s_data),
        .s_ready   (s_ready),
        .s_slot    (s_slot),
        .load      (slot_start),
        .load_slot (nxt_slot),
        .nslots    (slots_of(nxt_cfg)),
        .have      (have),
        .use_data  (use_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
            ws_q <= 1'b0;
            ur_q <= 1'b0;
        end else begin
            ur_q <= 1'b0;
            if (adv) begin
                ws_q <= ws_level(nxt_cfg, nxt_slot, nxt_bit);
                if (slot_start) begin
                    sh_q <= have ? align_sample(nxt_cfg, use_data) : '0;
                    ur_q <= !have;
                end else begin
                    sh_q <= sh_q << 1;
                end
            end
        end
    end

    assign sd       = sh_q[SMP_W-1];
    assign ws       = ws_q;
    assign underrun = ur_q;

    AST_SD_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        !$stable(sd) |-> $fell(bclk)); // R3

    AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        !$stable(ws) |-> $fell(bclk)); // R3

    AST_UNDERRUN_ZERO: assert property (@(posedge clk) disable iff (rst)
        underrun |-> (sh_q == '0)); // R9

    AST_FRAME_SLOT0: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (nxt_slot == '0)); // R7

endmodule

// File: tb/tb_audio_ser_top.sv
module tb_audio_ser_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  t_fmt = 2'd0, t_sel = 2'd0;
    logic [5:0]  t_w = 6'd32, t_l = 6'd32;
    logic [7:0]  t_div = 8'd0;
    logic        s_valid = 1'b0;
    logic [31:0] s_data = 32'd0;
    logic        s_ready, bclk, ws, sd, underrun;
    logic [4:0]  s_slot;
    logic        feed_en = 1'b0;
    logic        chk_per = 1'b0;
    int          nbits = 0;

    always #2 clk = ~clk;

    audio_ser_top dut (
        .clk(clk), .rst(rst), .cfg_fmt(t_fmt), .cfg_tdm_sel(t_sel),
        .cfg_slot_w(t_w), .cfg_word_len(t_l), .cfg_div(t_div),
        .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready), .s_slot(s_slot),
        .bclk(bclk), .ws(ws), .sd(sd), .underrun(underrun)
    );

    int n_total = 0, n_fail = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // sample queue filled by the feeder, drained by the monitor
    logic [31:0] qd [0:15];
    logic [4:0]  qt [0:15];
    logic [3:0]  qwr = 4'd0, qrd = 4'd0;
    logic        rdy_p = 1'b0;
    logic [4:0]  slot_p = 5'd0;

    always @(negedge clk) begin
        if (rst) begin
            qwr = 4'd0;
            rdy_p = 1'b0;
            s_valid = 1'b0;
        end else begin
            if (s_valid && rdy_p) begin
                qd[qwr] = s_data;
                qt[qwr] = slot_p;
                qwr = qwr + 4'd1;
            end
            rdy_p  = s_ready;
            slot_p = s_slot;
            if (feed_en && s_ready && ($urandom % 4) != 0) begin
                s_valid = 1'b1;
                s_data  = $urandom;
            end else begin
                s_valid = 1'b0;
            end
        end
    end

    function automatic logic e_sd(int fmt, int w, int l, int b, logic [31:0] d);
        if (fmt == 2) return (b >= w - l) ? d[w-1-b] : 1'b0;
        return (b < l) ? d[l-1-b] : 1'b0;
    endfunction

    function automatic logic e_ws(int fmt, int w, int n, int s, int b);
        int p;
        p = s * w + b;
        case (fmt)
            0: return (p >= w - 1) && (p < 2 * w - 1);
            3: return p == n * w - 1;
            default: return p < w;
        endcase
    endfunction

    // receiver-side monitor and model
    logic done = 1'b0, skip_first = 1'b1;
    int cap, ms, mb, m_w, m_l, m_fmt, m_n;
    logic [31:0] mcur;
    int bit_bad, bad_at, bad_act, bad_exp, r3_bad, ur_seen, zero_loads, r2_bad;
    int cyc = 0, last_rise;
    logic have_rise, p_bclk, p_sd, p_ws;

    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            done = 1'b0; skip_first = 1'b1; cap = 0; ms = 0; mb = 0;
            qrd = 4'd0; bit_bad = 0; bad_at = -1; bad_act = 0; bad_exp = 0;
            r3_bad = 0; ur_seen = 0; zero_loads = 0; r2_bad = 0;
            have_rise = 1'b0; mcur = 32'd0;
            m_w = 2; m_l = 1; m_fmt = 0; m_n = 2;
            p_bclk = bclk; p_sd = sd; p_ws = ws;
        end else if (!done) begin
            if ((sd !== p_sd || ws !== p_ws) && !(p_bclk && !bclk)) r3_bad++;
            if (underrun) ur_seen++;
            if (!p_bclk && bclk) begin
                if (chk_per && have_rise && (cyc - last_rise) != 2 * (int'(t_div) + 1))
                    r2_bad++;
                have_rise = 1'b1;
                last_rise = cyc;
                if (skip_first) begin
                    skip_first = 1'b0;
                end else begin
                    logic xs, xw;
                    if (mb == 0 && ms == 0) begin
                        m_w = t_w; m_l = t_l; m_fmt = t_fmt;
                        m_n = (t_fmt == 2'd3) ? (4 << t_sel) : 2;
                    end
                    if (mb == 0) begin
                        if (qwr != qrd && int'(qt[qrd]) == ms) begin
                            mcur = qd[qrd];
                            qrd = qrd + 4'd1;
                        end else begin
                            mcur = 32'd0;
                            zero_loads++;
                        end
                    end
                    xs = e_sd(m_fmt, m_w, m_l, mb, mcur);
                    xw = e_ws(m_fmt, m_w, m_n, ms, mb);
                    if (sd !== xs || ws !== xw) begin
                        bit_bad++;
                        if (bad_at < 0) begin
                            bad_at = cap;
                            bad_act = {ws, sd};
                            bad_exp = {xw, xs};
                        end
                    end
                    mb++;
                    if (mb == m_w) begin
                        mb = 0;
                        ms++;
                        if (ms == m_n) ms = 0;
                    end
                    cap++;
                    if (cap == nbits) done = 1'b1;
                end
            end
            p_bclk = bclk; p_sd = sd; p_ws = ws;
        end
    end

    task automatic start_phase(input int fmt, input int sel, input int w,
                               input int l, input int div, input int nb,
                               input bit feed);
        @(posedge clk); #1;
        rst = 1'b1; feed_en = 1'b0;
        t_fmt = 2'(fmt); t_sel = 2'(sel); t_w = 6'(w); t_l = 6'(l); t_div = 8'(div);
        nbits = nb;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        feed_en = feed;
    endtask

    task automatic wait_done();
        while (!done) @(posedge clk);
        #1;
        feed_en = 1'b0;
    endtask

    task automatic end_phase(input string req, input string name);
        check(bit_bad == 0, req,
              $sformatf("%s line bits wrong (first at bit %0d, ws/sd act %0d exp %0d)",
                        name, bad_at, bad_act, bad_exp), bit_bad, 0);
        check(r3_bad == 0, "R3", {name, " changes away from bclk fall"}, r3_bad, 0);
        check(ur_seen == zero_loads, "R9", {name, " underrun pulses vs empty slots"},
              ur_seen, zero_loads);
    endtask

    bit timed_out = 1'b0;

    initial begin
        void'($urandom(32'd20240611));
        fork
            begin
                // R1: reset state
                rst = 1'b1;
                repeat (4) @(posedge clk);
                @(negedge clk);
                check(bclk == 0 && ws == 0 && sd == 0 && underrun == 0, "R1",
                      "line outputs in reset", {bclk, ws, sd, underrun}, 0);
                check(s_ready == 1 && s_slot == 0, "R1", "handshake in reset",
                      {s_ready, s_slot}, 32);

                // R4 R11: I2S, 24-bit words in 32-bit slots
                start_phase(0, 0, 32, 24, 1, 192, 1'b1);
                wait_done();
                end_phase("R4", "i2s 32/24");

                // R4: I2S 16/16
                start_phase(0, 0, 16, 16, 0, 96, 1'b1);
                wait_done();
                end_phase("R4", "i2s 16/16");

                // R5 R11: left-justified
                start_phase(1, 0, 16, 16, 0, 96, 1'b1);
                wait_done();
                end_phase("R5", "lj 16/16");
                start_phase(1, 0, 32, 18, 2, 128, 1'b1);
                wait_done();
                end_phase("R5", "lj 32/18");

                // R6: right-justified
                start_phase(2, 0, 32, 20, 2, 192, 1'b1);
                wait_done();
                end_phase("R6", "rj 32/20");
                start_phase(2, 0, 8, 8, 0, 64, 1'b1);
                wait_done();
                end_phase("R6", "rj 8/8");

                // R7: TDM 8 slots and 32 slots
                start_phase(3, 1, 16, 12, 0, 384, 1'b1);
                wait_done();
                end_phase("R7", "tdm8 16/12");
                start_phase(3, 3, 32, 32, 0, 2048, 1'b1);
                wait_done();
                end_phase("R7", "tdm32 32/32");

                // R9 R8: starve the block, then resume feeding
                start_phase(0, 0, 16, 16, 1, 128, 1'b0);
                while (cap < 40) @(posedge clk);
                @(negedge clk);
                check(s_ready == 1'b1, "R8", "ready held while starved", s_ready, 1);
                #1;
                feed_en = 1'b1;
                wait_done();
                check(ur_seen > 0, "R9", "underrun seen when starved", ur_seen, 1);
                end_phase("R9", "starved i2s");

                // R10: change of everything in mid-frame
                start_phase(1, 0, 16, 16, 1, 160, 1'b1);
                while (cap < 7) @(posedge clk);
                #1;
                t_fmt = 2'd3; t_sel = 2'd0; t_w = 6'd8; t_l = 6'd8; t_div = 8'd0;
                wait_done();
                end_phase("R10", "mid-frame change");

                // R2: bit period for a wider divider
                chk_per = 1'b1;
                start_phase(2, 0, 16, 10, 4, 64, 1'b1);
                wait_done();
                chk_per = 1'b0;
                check(r2_bad == 0, "R2", "bclk periods off 2*(div+1)", r2_bad, 0);
                end_phase("R6", "rj div4");
            end
            begin
                repeat (190000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) check(1'b0, "R1", "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule